// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches one of two external 16-bit free-running timers and compares the chosen count with a programmable 16-bit compare value on every clock. When the two become equal, the unit performs the action that its 4-bit mode field selects. It can drive an output latch high, drive it low, or toggle it. It can also leave the latch alone and only raise the interrupt flag. In the last mode it raises a one-cycle event trigger. That trigger resets the timer in use, so the compare value works as a programmable period, and it can also start an analog-to-digital conversion.

Software loads the compare value through one write strobe. The mode and timer select are loaded together through a second strobe. The interrupt flag is held until a clear strobe arrives. The pin direction is a separate control input: the latch is driven onto the pin only when that input selects output, and otherwise the pin is released. The timers and the converter sit outside this block.

Top module: `tcmp_top`

## Requirements
- R1: The compare value is checked against `tmr_a` when the timer select bit is 0 and against `tmr_b` when it is 1. Equality on the timer that is not selected has no effect.
- R2: On a match, mode 4'b1000 sets the latch, mode 4'b1001 clears it and mode 4'b0010 inverts it. The latch value appears on `pin_out` after the clock edge that samples the equality.
- R3: A match in any of the five active modes (1000, 1001, 0010, 1010, 1011) sets `irq_flag`. The flag stays set until `flag_clr` is pulsed. If a match and a clear arrive in the same cycle, the match wins.
- R4: In mode 4'b1010 a match sets the flag and leaves the latch unchanged.
- R5: In mode 4'b1011 a match produces a single one-cycle pulse on the reset output of the selected timer only (`tmr_a_rst` for select 0, `tmr_b_rst` for select 1). The pulse starts in the cycle after the matching edge, and the latch is left unchanged.
- R6: With the converter option built in, `adc_go` pulses together with the trigger of R5 when `adc_en` is high, and stays low when `adc_en` is low.
- R7: Mode 4'b0000 and every code not listed in R3 hold the latch low and never set the flag. Writing 4'b0000 to the control forces a high latch low at the edge of that write.
- R8: Each equality event is acted on once. The action fires on the cycle in which equality starts, and holding the timer at the matching value does not repeat it, even in toggle mode or after a mode change.
- R9: `pin_oe` follows `oe_dir`. The pin is driven only while `pin_oe` is 1.
- R10: After reset, every output except `pin_oe` is 0. The mode is off, the compare value is 0 and timer A is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_val | input | 1 | Load strobe for the compare value |
| wr_data | input | 16 | New compare value |
| wr_ctl | input | 1 | Load strobe for mode and timer select |
| wr_mode | input | 4 | New mode code |
| wr_tsel | input | 1 | New timer select (0 = A, 1 = B) |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| oe_dir | input | 1 | Pin direction control, 1 = output |
| adc_en | input | 1 | Converter enabled |
| tmr_a_rst | output | 1 | One-cycle reset request to timer A |
| tmr_b_rst | output | 1 | One-cycle reset request to timer B |
| pin_out | output | 1 | Compare output latch |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Interrupt flag |
| adc_go | output | 1 | One-cycle conversion-start strobe |

## Verification
Several rules are checked by the assertions on every cycle. Every active match is followed by a set flag. The latch is held in software-interrupt mode and stays low in inactive modes. Timer resets are single pulses that never overlap. The conversion strobe never appears without a trigger. A match event is never repeated in the next cycle.

Other behaviour can only be shown by the bench's scenarios. These are the exact set, clear and toggle results, and the fact that equality on the unselected timer is ignored. They also include the clear-versus-match priority on the flag, the forced-low write, and the absence of a second action while the timer stays at the matching value.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int TW     = 16;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] M_OFF = 4'b0000;
  localparam logic [MODE_W-1:0] M_TOG = 4'b0010;
  localparam logic [MODE_W-1:0] M_SET = 4'b1000;
  localparam logic [MODE_W-1:0] M_CLR = 4'b1001;
  localparam logic [MODE_W-1:0] M_SWI = 4'b1010;
  localparam logic [MODE_W-1:0] M_SEV = 4'b1011;

  // Active modes are the five listed codes; everything else behaves as off.
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return (m == M_TOG) || (m == M_SET) || (m == M_CLR) ||
           (m == M_SWI) || (m == M_SEV);
  endfunction

  // Next latch value for an active mode, given a match event.
  function automatic logic next_latch(input logic [MODE_W-1:0] m,
                                      input logic cur, input logic hit);
    logic r;
    r = cur;
    if (hit) begin
      case (m)
        M_SET:   r = 1'b1;
        M_CLR:   r = 1'b0;
        M_TOG:   r = ~cur;
        default: r = cur;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tcmp_cfg.sv
module tcmp_cfg
  import tcmp_pkg::*;
#(
  parameter int W = TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_val,
  input  logic [W-1:0]      wr_data,
  input  logic              wr_ctl,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_tsel,
  output logic [W-1:0]      cmp_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              tsel_q,
  output logic              force_low
);
  assign force_low = wr_ctl && (wr_mode == M_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= M_OFF;
      tsel_q <= 1'b0;
    end else begin
      if (wr_val) cmp_q <= wr_data;
      if (wr_ctl) begin
        mode_q <= wr_mode;
        tsel_q <= wr_tsel;
      end
    end
  end
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match
  import tcmp_pkg::*;
#(
  parameter int W = TW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  input  logic         tsel,
  input  logic [W-1:0] cmp,
  output logic         eq_now,
  output logic         match_ev
);
  logic [W-1:0] src;
  logic         eq_q;

  assign src      = tsel ? tmr_b : tmr_a;
  assign eq_now   = (src == cmp);
  assign match_ev = eq_now && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
  import tcmp_pkg::*;
#(
  parameter bit HAS_ADC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              tsel,
  input  logic              match_ev,
  input  logic              force_low,
  input  logic              flag_clr,
  input  logic              adc_en,
  output logic              latch,
  output logic              irq,
  output logic              trig_a,
  output logic              trig_b,
  output logic              go
);
  logic active;
  logic sev_hit;

  assign active  = mode_active(mode);
  assign sev_hit = (mode == M_SEV) && match_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch  <= 1'b0;
      irq    <= 1'b0;
      trig_a <= 1'b0;
      trig_b <= 1'b0;
    end else begin
      if (force_low || !active) latch <= 1'b0;
      else                      latch <= next_latch(mode, latch, match_ev);
      if (active && match_ev) irq <= 1'b1;
      else if (flag_clr)      irq <= 1'b0;
      trig_a <= sev_hit && !tsel;
      trig_b <= sev_hit && tsel;
    end
  end

  generate
    if (HAS_ADC) begin : g_adc
      logic go_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= sev_hit && adc_en;
      end
      assign go = go_q;
    end else begin : g_no_adc
      assign go = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
  import tcmp_pkg::*;
#(
  parameter int W       = TW,
  parameter bit HAS_ADC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_val,
  input  logic [W-1:0]      wr_data,
  input  logic              wr_ctl,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_tsel,
  input  logic              flag_clr,
  input  logic [W-1:0]      tmr_a,
  input  logic [W-1:0]      tmr_b,
  input  logic              oe_dir,
  input  logic              adc_en,
  output logic              tmr_a_rst,
  output logic              tmr_b_rst,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              adc_go
);
  logic [W-1:0]      cmp_q;
  logic [MODE_W-1:0] mode_q;
  logic              tsel_q;
  logic              force_low;
  logic              eq_now;
  logic              match_ev;
  logic              latch;

  tcmp_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_val(wr_val), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .wr_mode(wr_mode), .wr_tsel(wr_tsel),
    .cmp_q(cmp_q), .mode_q(mode_q), .tsel_q(tsel_q), .force_low(force_low)
  );

  tcmp_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .tsel(tsel_q), .cmp(cmp_q),
    .eq_now(eq_now), .match_ev(match_ev)
  );

  tcmp_action #(.HAS_ADC(HAS_ADC)) u_act (
    .clk(clk), .rst_n(rst_n),
    .mode(mode_q), .tsel(tsel_q), .match_ev(match_ev),
    .force_low(force_low), .flag_clr(flag_clr), .adc_en(adc_en),
    .latch(latch), .irq(irq_flag),
    .trig_a(tmr_a_rst), .trig_b(tmr_b_rst), .go(adc_go)
  );

  assign pin_out = latch;
  assign pin_oe  = oe_dir;
endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker
  import tcmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              match_ev,
  input logic [MODE_W-1:0] mode_q,
  input logic              wr_ctl,
  input logic              pin_out,
  input logic              irq_flag,
  input logic              tmr_a_rst,
  input logic              tmr_b_rst,
  input logic              adc_go
);
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode_active(mode_q)) |=> irq_flag);

  p_swi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SWI && !wr_ctl) |=> $stable(pin_out));

  p_trig_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_a_rst || tmr_b_rst) |=> !(tmr_a_rst || tmr_b_rst));

  p_trig_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_a_rst, tmr_b_rst}));

  p_go_with_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_go |-> (tmr_a_rst || tmr_b_rst));

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active(mode_q) |=> !pin_out);

  p_edge_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> !match_ev);
endmodule

bind tcmp_top tcmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .mode_q(mode_q),
  .wr_ctl(wr_ctl), .pin_out(pin_out), .irq_flag(irq_flag),
  .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst), .adc_go(adc_go)
);

// File: tb/test_tcmp_top.sv
`timescale 1ns/1ps
module test_tcmp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_val = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ctl = 1'b0;
  logic [3:0]  wr_mode = '0;
  logic        wr_tsel = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] tmr_a = '0;
  logic [15:0] tmr_b = '0;
  logic        oe_dir = 1'b0;
  logic        adc_en = 1'b0;
  logic        tmr_a_rst, tmr_b_rst, pin_out, pin_oe, irq_flag, adc_go;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string      req;
    logic [5:0] exp;
  } item_t;
  item_t sb[$];
  event  ev_chk;

  always #5 clk = ~clk;

  tcmp_top i_tcmp_top (
    .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .wr_mode(wr_mode), .wr_tsel(wr_tsel), .flag_clr(flag_clr),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .oe_dir(oe_dir), .adc_en(adc_en),
    .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_flag(irq_flag), .adc_go(adc_go)
  );

  // observed vector: {pin_oe, pin_out, irq_flag, tmr_a_rst, tmr_b_rst, adc_go}
  function automatic logic [5:0] ex(input logic oe, input logic pin, input logic irq,
                                    input logic ra, input logic rb, input logic go);
    return {oe, pin, irq, ra, rb, go};
  endfunction

  // Monitor: pops expectations and compares with the ports.
  initial begin
    forever begin
      @(ev_chk);
      while (sb.size() > 0) begin
        item_t it;
        logic [5:0] obs;
        it  = sb.pop_front();
        obs = {pin_oe, pin_out, irq_flag, tmr_a_rst, tmr_b_rst, adc_go};
        n_total++;
        if (obs !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b (oe,pin,irq,rsta,rstb,go)",
                   it.req, obs, it.exp);
        end
      end
    end
  end

  task automatic expect_now(input string req, input logic [5:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    sb.push_back(it);
    -> ev_chk;
    wait (sb.size() == 0);
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b);
    tmr_a = a;
    tmr_b = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    wr_val  = 1'b1;
    wr_data = v;
    @(posedge clk);
    @(negedge clk);
    wr_val  = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [3:0] m, input logic s);
    wr_ctl  = 1'b1;
    wr_mode = m;
    wr_tsel = s;
    @(posedge clk);
    @(negedge clk);
    wr_ctl  = 1'b0;
  endtask

  task automatic clr_step(input logic [15:0] a, input logic [15:0] b);
    flag_clr = 1'b1;
    step(a, b);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R10 reset", ex(0,0,0,0,0,0));
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R10 after release", ex(0,0,0,0,0,0));

    oe_dir = 1'b1;
    wr_cmp(16'd100);
    wr_ctrl(4'b1000, 1'b0);
    step(16'd50, 16'd0);
    expect_now("R1 no equality", ex(1,0,0,0,0,0));
    step(16'd100, 16'd0);
    expect_now("R2 set on match", ex(1,1,1,0,0,0));
    clr_step(16'd100, 16'd0);
    expect_now("R3 flag cleared, R8 held value no rematch", ex(1,1,0,0,0,0));

    wr_ctrl(4'b1001, 1'b0);
    step(16'd100, 16'd0);
    expect_now("R8 mode change while equal", ex(1,1,0,0,0,0));
    step(16'd101, 16'd0);
    step(16'd100, 16'd0);
    expect_now("R2 clear on match", ex(1,0,1,0,0,0));
    clr_step(16'd101, 16'd0);

    wr_ctrl(4'b0010, 1'b0);
    step(16'd100, 16'd0);
    expect_now("R2 toggle to high", ex(1,1,1,0,0,0));
    step(16'd100, 16'd0);
    step(16'd100, 16'd0);
    step(16'd100, 16'd0);
    expect_now("R8 no re-toggle while held", ex(1,1,1,0,0,0));
    step(16'd101, 16'd0);
    clr_step(16'd100, 16'd0);
    expect_now("R3 match beats clear, R2 toggle low", ex(1,0,1,0,0,0));

    wr_ctrl(4'b1000, 1'b1);
    clr_step(16'd0, 16'd0);
    expect_now("R3 flag clear", ex(1,0,0,0,0,0));
    step(16'd100, 16'd5);
    expect_now("R1 unselected timer ignored", ex(1,0,0,0,0,0));
    step(16'd5, 16'd100);
    expect_now("R1 timer B match", ex(1,1,1,0,0,0));

    wr_ctrl(4'b1010, 1'b1);
    clr_step(16'd0, 16'd0);
    step(16'd0, 16'd100);
    expect_now("R4 swi flag only", ex(1,1,1,0,0,0));

    wr_ctrl(4'b1011, 1'b0);
    adc_en = 1'b1;
    clr_step(16'd0, 16'd0);
    step(16'd100, 16'd0);
    expect_now("R5 R6 trigger on timer A with go", ex(1,1,1,1,0,1));
    step(16'd0, 16'd0);
    expect_now("R5 trigger lasts one cycle", ex(1,1,1,0,0,0));
    wr_ctrl(4'b1011, 1'b1);
    adc_en = 1'b0;
    step(16'd0, 16'd100);
    expect_now("R5 R6 trigger on timer B, no go", ex(1,1,1,0,1,0));
    step(16'd0, 16'd0);

    wr_ctrl(4'b0000, 1'b0);
    expect_now("R7 zero write forces low", ex(1,0,1,0,0,0));
    clr_step(16'd0, 16'd0);
    wr_ctrl(4'b0101, 1'b0);
    step(16'd1, 16'd0);
    step(16'd100, 16'd0);
    expect_now("R7 unlisted code inert", ex(1,0,0,0,0,0));

    oe_dir = 1'b0;
    step(16'd0, 16'd0);
    expect_now("R9 output released", ex(0,0,0,0,0,0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule